// File: doc/BRIEF.md
# Accumulator Register-Transfer Core

This block is a small execution core. It holds two data registers: an accumulator and one general-purpose register. On each clock edge where the qualifying strobe is high, it executes one instruction chosen by a 4-bit opcode. It can load either register from an input data bus, copy the accumulator into the general register, and publish either register on a registered output port. It can also combine the two registers with addition, bitwise OR or bitwise AND, or invert the accumulator. Every arithmetic or logic result goes back into the accumulator.

A surrounding sequencer or test harness drives the opcode, the strobe and the input bus, and reads results from the output port. The block has no fetch logic, no memory, no flags and no program counter. Opcodes outside the ten defined ones are treated as no-operations. The data width is a parameter with a default of 8 bits.

Top module: `acc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the accumulator, the general register and `dout` to zero. This reset takes priority over a valid instruction presented in the same cycle.
- R2: With `valid` high, opcode 1 and opcode 6 both load the accumulator from `din`.
- R3: With `valid` high, opcode 5 loads the general register from `din`, and opcode 2 copies the accumulator into the general register.
- R4: Opcode 3 places the general register on `dout`, and opcode 4 places the accumulator on `dout`. The new value is visible after the same clock edge that executes the instruction.
- R5: Opcode 7 writes the sum of the accumulator and the general register into the accumulator, modulo 2^WIDTH. The carry out is discarded.
- R6: Opcode 8 writes accumulator OR general register into the accumulator, and opcode 9 writes accumulator AND general register into the accumulator.
- R7: Opcode 10 writes the bitwise complement of the accumulator into the accumulator.
- R8: The general register keeps its value under every instruction except opcodes 2 and 5.
- R9: `dout` keeps its last value unless opcode 3 or opcode 4 executes.
- R10: Opcodes 0 and 11 through 15 change no state. Any opcode presented with `valid` low also changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Qualifies the opcode for execution in this cycle |
| opcode | input | 4 | Instruction code, values 1 to 10 defined |
| din | input | WIDTH | External input data bus |
| dout | output | WIDTH | Registered output port |

## Verification
Two functions can land in the same cycle: reset, and the execution of a valid instruction. The bench raises reset while a valid accumulator load with a non-zero operand is on the inputs. It then requires `dout` to read zero and both registers to read zero when published afterwards. A second overlap is an accumulator write directly followed by its publication: the bench publishes each ALU result in the very next step and compares it with a value worked out by hand, including the wrapped sum.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [3:0] {
        OP_IDLE0   = 4'd0,
        OP_LOADA   = 4'd1,
        OP_COPYAR  = 4'd2,
        OP_EMITR   = 4'd3,
        OP_EMITA   = 4'd4,
        OP_LOADR   = 4'd5,
        OP_LOADA2  = 4'd6,
        OP_SUM     = 4'd7,
        OP_BOR     = 4'd8,
        OP_BAND    = 4'd9,
        OP_INV     = 4'd10
    } opcode_e;

    typedef enum logic [1:0] {
        ASRC_KEEP = 2'd0,
        ASRC_BUS  = 2'd1,
        ASRC_ALU  = 2'd2
    } asrc_e;

    typedef enum logic [1:0] {
        RSRC_KEEP = 2'd0,
        RSRC_BUS  = 2'd1,
        RSRC_ACC  = 2'd2
    } rsrc_e;

    typedef enum logic [1:0] {
        OSRC_KEEP = 2'd0,
        OSRC_ACC  = 2'd1,
        OSRC_GEN  = 2'd2
    } osrc_e;

    typedef enum logic [1:0] {
        FN_SUM = 2'd0,
        FN_OR  = 2'd1,
        FN_AND = 2'd2,
        FN_INV = 2'd3
    } alufn_e;

    typedef struct packed {
        asrc_e  a_src;
        rsrc_e  r_src;
        osrc_e  o_src;
        alufn_e fn;
    } ctrl_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
(
    input  logic       valid,
    input  logic [3:0] opcode,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl.a_src = ASRC_KEEP;
        ctrl.r_src = RSRC_KEEP;
        ctrl.o_src = OSRC_KEEP;
        ctrl.fn    = FN_SUM;
        if (valid) begin
            case (opcode)
                OP_LOADA,
                OP_LOADA2: ctrl.a_src = ASRC_BUS;
                OP_COPYAR: ctrl.r_src = RSRC_ACC;
                OP_LOADR:  ctrl.r_src = RSRC_BUS;
                OP_EMITR:  ctrl.o_src = OSRC_GEN;
                OP_EMITA:  ctrl.o_src = OSRC_ACC;
                OP_SUM: begin
                    ctrl.a_src = ASRC_ALU;
                    ctrl.fn    = FN_SUM;
                end
                OP_BOR: begin
                    ctrl.a_src = ASRC_ALU;
                    ctrl.fn    = FN_OR;
                end
                OP_BAND: begin
                    ctrl.a_src = ASRC_ALU;
                    ctrl.fn    = FN_AND;
                end
                OP_INV: begin
                    ctrl.a_src = ASRC_ALU;
                    ctrl.fn    = FN_INV;
                end
                default: ;
            endcase
        end
    end

    // At most one destination is written per instruction (R8, R9, R10)
    always_comb begin
        a_onehot_dest_r10: assert ($onehot0({ctrl.a_src != ASRC_KEEP,
                                             ctrl.r_src != RSRC_KEEP,
                                             ctrl.o_src != OSRC_KEEP}))
            else $error("decoder selected more than one destination");
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alufn_e           fn,
    output logic [WIDTH-1:0] y
);

    logic [WIDTH-1:0] carry;
    logic [WIDTH-1:0] sum_w;
    logic [WIDTH-1:0] or_w;
    logic [WIDTH-1:0] and_w;
    logic [WIDTH-1:0] inv_w;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum_w[i] = a[i] ^ b[i] ^ carry[i];
        assign or_w[i]  = a[i] | b[i];
        assign and_w[i] = a[i] & b[i];
        assign inv_w[i] = ~a[i];
        if (i < WIDTH - 1) begin : g_chain
            assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
        end
    end

    always_comb begin
        case (fn)
            FN_SUM:  y = sum_w;
            FN_OR:   y = or_w;
            FN_AND:  y = and_w;
            default: y = inv_w;
        endcase
    end

    // The ripple chain must match modular addition (R5)
    always_comb begin
        a_sum_wraps_r5: assert (sum_w == WIDTH'(a + b))
            else $error("ripple sum disagrees with modular sum");
    end

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic [3:0]       opcode,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [WIDTH-1:0] acc;
        logic [WIDTH-1:0] gen;
        logic [WIDTH-1:0] out;
    } state_t;

    state_t           st_d, st_q;
    ctrl_t            ctrl;
    logic [WIDTH-1:0] alu_y;
    logic             rst_seen_q;

    acc_decode u_decode (
        .valid  (valid),
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    acc_alu #(.WIDTH(WIDTH)) u_alu (
        .a  (st_q.acc),
        .b  (st_q.gen),
        .fn (ctrl.fn),
        .y  (alu_y)
    );

    always_comb begin
        st_d = st_q;
        case (ctrl.a_src)
            ASRC_BUS: st_d.acc = din;
            ASRC_ALU: st_d.acc = alu_y;
            default:  ;
        endcase
        case (ctrl.r_src)
            RSRC_BUS: st_d.gen = din;
            RSRC_ACC: st_d.gen = st_q.acc;
            default:  ;
        endcase
        case (ctrl.o_src)
            OSRC_ACC: st_d.out = st_q.acc;
            OSRC_GEN: st_d.out = st_q.gen;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
        rst_seen_q <= rst;
    end

    assign dout = st_q.out;

    logic fire;
    assign fire = valid && !rst;

    // R1: one cycle after reset every register reads zero
    always_comb begin
        if (rst_seen_q == 1'b1) begin
            a_reset_zero_r1: assert (st_q == '0)
                else $error("state not cleared by reset");
        end
    end

    // R8: the general register is written only by opcodes 2 and 5
    p_gen_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(fire && (opcode == OP_COPYAR || opcode == OP_LOADR)) |=> $stable(st_q.gen));

    // R9: the output port moves only on opcodes 3 and 4
    p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(fire && (opcode == OP_EMITR || opcode == OP_EMITA)) |=> $stable(dout));

    // R4: publishing the accumulator shows its value before the edge
    p_emit_acc_r4: assert property (@(posedge clk) disable iff (rst)
        (fire && opcode == OP_EMITA) |=> dout == $past(st_q.acc));

    // R3: copy from accumulator into the general register
    p_copy_r3: assert property (@(posedge clk) disable iff (rst)
        (fire && opcode == OP_COPYAR) |=> st_q.gen == $past(st_q.acc));

    // R2: both load opcodes take the bus
    p_load_acc_r2: assert property (@(posedge clk) disable iff (rst)
        (fire && (opcode == OP_LOADA || opcode == OP_LOADA2)) |=> st_q.acc == $past(din));

    // R7: complement of the accumulator
    p_invert_r7: assert property (@(posedge clk) disable iff (rst)
        (fire && opcode == OP_INV) |=> st_q.acc == ~$past(st_q.acc));

    // R10: unqualified or undefined opcodes keep all state
    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!valid || opcode == 4'd0 || opcode > 4'd10) |=> $stable(st_q));

endmodule

// File: tb/sim_acc_core.sv
module sim_acc_core;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         valid = 1'b0;
    logic [3:0]   opcode = 4'd0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    acc_core #(.WIDTH(W)) u0 (
        .clk    (clk),
        .rst    (rst),
        .valid  (valid),
        .opcode (opcode),
        .din    (din),
        .dout   (dout)
    );

    typedef struct packed {
        logic         v;
        logic [3:0]   op;
        logic [W-1:0] d;
        logic [W-1:0] exp;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 4'd1,  8'h3C, 8'h00},  // R2 load acc = 3C
        '{1'b1, 4'd4,  8'h00, 8'h3C},  // R4 emit acc
        '{1'b1, 4'd5,  8'hA5, 8'h3C},  // R3 load gen = A5, R9 out holds
        '{1'b1, 4'd3,  8'h00, 8'hA5},  // R4 emit gen
        '{1'b1, 4'd7,  8'h00, 8'hA5},  // R5 acc = E1
        '{1'b1, 4'd4,  8'h00, 8'hE1},  // R5 check sum
        '{1'b1, 4'd8,  8'h00, 8'hE1},  // R6 acc = E5
        '{1'b1, 4'd4,  8'h00, 8'hE5},  // R6 check OR
        '{1'b1, 4'd9,  8'h00, 8'hE5},  // R6 acc = A5
        '{1'b1, 4'd4,  8'h00, 8'hA5},  // R6 check AND
        '{1'b1, 4'd10, 8'h00, 8'hA5},  // R7 acc = 5A
        '{1'b1, 4'd4,  8'h00, 8'h5A},  // R7 check invert
        '{1'b1, 4'd2,  8'h00, 8'h5A},  // R3 gen = acc = 5A
        '{1'b1, 4'd6,  8'hFF, 8'h5A},  // R2 alternate load acc = FF
        '{1'b1, 4'd3,  8'h00, 8'h5A},  // R8 gen kept 5A
        '{1'b1, 4'd7,  8'h00, 8'h5A},  // R5 FF+5A wraps to 59
        '{1'b1, 4'd4,  8'h00, 8'h59},  // R5 carry dropped
        '{1'b0, 4'd1,  8'h11, 8'h59},  // R10 unqualified load
        '{1'b0, 4'd4,  8'h00, 8'h59},  // R10 unqualified emit
        '{1'b1, 4'd0,  8'h22, 8'h59},  // R10 opcode 0
        '{1'b1, 4'd12, 8'h33, 8'h59},  // R10 opcode 12
        '{1'b1, 4'd15, 8'h44, 8'h59},  // R10 opcode 15
        '{1'b1, 4'd4,  8'h00, 8'h59},  // R10 acc untouched
        '{1'b1, 4'd3,  8'h00, 8'h5A},  // R8 gen untouched by ALU ops
        '{1'b1, 4'd1,  8'h00, 8'h5A},  // R2 load zero
        '{1'b1, 4'd10, 8'h00, 8'h5A},  // R7 acc = FF
        '{1'b1, 4'd4,  8'h00, 8'hFF}   // R7 complement of zero
    };

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: dout=%h expected=%h", tag, got, exp);
        end
    endtask

    // drives at a falling edge, samples at the next falling edge
    task automatic apply(input logic v, input logic [3:0] op, input logic [W-1:0] d);
        valid  = v;
        opcode = op;
        din    = d;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset out", dout, 8'h00);
        apply(1'b1, 4'd4, 8'hAA);
        check("R1 reset acc", dout, 8'h00);
        apply(1'b1, 4'd3, 8'hAA);
        check("R1 reset gen", dout, 8'h00);

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i].v, TBL[i].op, TBL[i].d);
            check($sformatf("vector %0d op %0d", i, TBL[i].op), dout, TBL[i].exp);
        end

        // R1: reset and a valid load in the same cycle, reset wins
        rst = 1'b1;
        apply(1'b1, 4'd1, 8'h77);
        rst = 1'b0;
        check("R1 reset over load, out", dout, 8'h00);
        apply(1'b1, 4'd4, 8'h00);
        check("R1 reset over load, acc", dout, 8'h00);
        apply(1'b1, 4'd3, 8'h00);
        check("R1 reset over load, gen", dout, 8'h00);

        // R3 bus load of gen straight after reset, R9 hold on idle
        apply(1'b1, 4'd5, 8'h81);
        check("R9 out held on gen load", dout, 8'h00);
        apply(1'b1, 4'd3, 8'h00);
        check("R3 gen from bus", dout, 8'h81);
        apply(1'b0, 4'd0, 8'h00);
        check("R9 out held idle", dout, 8'h81);

        valid = 1'b0;
        done  = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule